// File: doc/BRIEF.md
# Dual-Bus Command and Data Word Validator

This block sits behind two Manchester decoders, one on each of a pair of redundant serial buses. Each cycle that a decoder reports a finished word, the block decides whether that word is a valid command for this terminal, a valid data word belonging to the message in progress, or neither. A finished word is a strobe together with its sync type, 16 data bits, the received parity bit and a bi-phase error flag.

Whether a word is a command or data depends on timing as well as sync type. A command must arrive after a quiet period on its bus. A data word must arrive inside the contiguity window that follows an accepted word on the same bus. The window is counted in bit times derived from the clock. When a command is accepted on one bus while the other bus still has a message open, the old message is cut off and an abort strobe is raised. The new command then takes over. An accepted command produces an active-low pulse of fixed length, and the command word and its bus are held on the outputs throughout that pulse. The terminal address is sampled while reset is asserted.

Top module: `bus_word_validator`

## Requirements
- R1: A word is good only if the bi-phase error flag is low and its 16 data bits together with the parity bit hold an odd number of ones. A word that is not good is never accepted.
- R2: A command word has the command sync type (sync_cmd = 1) and an address field in bits 15:11 equal to the latched terminal address or to 5'b11111. cmd_bcast is 1 for a command accepted with address 5'b11111 and 0 for any other accepted command.
- R3: A command is accepted only when its bus has no open window. A window opens when a word on that bus is accepted. It stays open for at least (WORD_BITS+GAP_BITS-1) bit times and closes after at most (WORD_BITS+GAP_BITS) bit times. One bit time is CLKS_PER_BIT clocks.
- R4: A data word (sync_cmd = 0) is accepted only while its bus has an open window. data_stb is high for the one cycle after the edge that sampled the word, with data_word and data_bus (0 = bus A, 1 = bus B).
- R5: An accepted command drives cmd_n low for exactly PULSE_CLKS cycles, starting in the cycle after the sampling edge. cmd_word and cmd_bus hold that command throughout the pulse. A newer accepted command restarts the pulse with the new word.
- R6: If a command is accepted on one bus while the other bus has an open window, abort_stb is high for one cycle, together with the start of the new pulse. The other bus's window closes, so its following data words are rejected. A data word on the other bus in that same cycle is dropped.
- R7: rt_addr is sampled only while rst is high. After reset, cmd_n is 1, data_stb and abort_stb are 0, and the word outputs are 0. No data word is accepted before a command.
- R8: Any word strobe on a bus that is not accepted closes that bus's window. Data words that follow it on that bus are rejected.
- R9: If both buses present an acceptable command in the same cycle, bus A's command is taken. Bus B's word is treated as rejected and no abort is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; terminal address sampled while high |
| rt_addr | input | 5 | Terminal address |
| a_rdy | input | 1 | Bus A word finished strobe |
| a_sync_cmd | input | 1 | Bus A sync type, 1 = command/status sync |
| a_data | input | 16 | Bus A data bits |
| a_parity | input | 1 | Bus A received parity bit |
| a_man_err | input | 1 | Bus A bi-phase error flag |
| b_rdy | input | 1 | Bus B word finished strobe |
| b_sync_cmd | input | 1 | Bus B sync type, 1 = command/status sync |
| b_data | input | 16 | Bus B data bits |
| b_parity | input | 1 | Bus B received parity bit |
| b_man_err | input | 1 | Bus B bi-phase error flag |
| cmd_n | output | 1 | Active-low valid-command pulse |
| cmd_word | output | 16 | Last accepted command word |
| cmd_bus | output | 1 | Bus of the last accepted command |
| cmd_bcast | output | 1 | Last accepted command was broadcast |
| data_stb | output | 1 | Valid data word strobe |
| data_word | output | 16 | Accepted data word |
| data_bus | output | 1 | Bus of the accepted data word |
| abort_stb | output | 1 | Message on the other bus terminated |

## Verification
The bench drives word chains with gaps that fall clearly inside or clearly outside the contiguity window. A design that mixed up the two cases would take data words as stray commands, or take late data as part of a finished message. It also sends words that are rejected in the middle of a chain (bad parity, a bi-phase error, a contiguous command). A design that left the window open after such a word would go on accepting the data that follows. Commands that collide across the buses are sent both in the same cycle and a few cycles apart, together with data on the losing bus. A wrong arbiter would emit two commands, miss the abort, keep the old bus's data, or leave the pulse holding the old word. Commands are also sent to the address driven after reset. A design that tracks rt_addr instead of latching it would accept them.

// File: rtl/bwv_pkg.sv
package bwv_pkg;
  localparam int DW        = 16;
  localparam int AW        = 5;
  localparam int ADDR_LSB  = DW - AW;
  localparam logic [AW-1:0] BCAST_ADDR = '1;

  typedef struct packed {
    logic          rdy;
    logic          sync_cmd;
    logic [DW-1:0] data;
    logic          parity;
    logic          man_err;
  } bus_word_t;
endpackage

// File: rtl/bwv_bit_tick.sv
module bwv_bit_tick #(
  parameter int CLKS_PER_BIT = 250
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + 1'b1;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);
endmodule

// File: rtl/bwv_word_check.sv
module bwv_word_check
  import bwv_pkg::*;
#(
  parameter int WINDOW_BITS = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_tick,
  input  bus_word_t     w,
  input  logic [AW-1:0] rt_addr,
  input  logic          take,
  input  logic          cancel,
  output logic          cmd_cand,
  output logic          data_cand,
  output logic          open_win
);
  localparam int GW = (WINDOW_BITS > 1) ? $clog2(WINDOW_BITS) : 1;
  localparam logic [GW-1:0] GLAST = GW'(WINDOW_BITS - 1);

  logic          word_ok;
  logic          addr_hit;
  logic [AW-1:0] addr_f;
  logic [GW-1:0] gcnt;

  // R1: clean bi-phase and odd ones count over data plus parity
  assign word_ok  = !w.man_err && (^{w.data, w.parity});
  assign addr_f   = w.data[DW-1:ADDR_LSB];
  assign addr_hit = (addr_f == rt_addr) || (addr_f == BCAST_ADDR);

  assign cmd_cand  = w.rdy &&  w.sync_cmd && word_ok && addr_hit && !open_win;
  assign data_cand = w.rdy && !w.sync_cmd && word_ok && open_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_win <= 1'b0;
      gcnt     <= '0;
    end else if (take) begin
      open_win <= 1'b1;
      gcnt     <= '0;
    end else if (w.rdy || cancel) begin
      open_win <= 1'b0;
      gcnt     <= '0;
    end else if (open_win && bit_tick) begin
      if (gcnt == GLAST) begin
        open_win <= 1'b0;
        gcnt     <= '0;
      end else begin
        gcnt <= gcnt + 1'b1;
      end
    end
  end

  // R8
  reject_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (w.rdy && !take) |=> !open_win);
  // R3
  take_opens_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> open_win);
  // R3
  gap_range_chk: assert property (@(posedge clk) disable iff (rst)
    gcnt <= GLAST);
endmodule

// File: rtl/bwv_msg_out.sv
module bwv_msg_out
  import bwv_pkg::*;
#(
  parameter int PULSE_CLKS = 125
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant_a,
  input  logic          grant_b,
  input  logic          pass_a,
  input  logic          pass_b,
  input  logic          abort_in,
  input  logic [DW-1:0] word_a,
  input  logic [DW-1:0] word_b,
  output logic          cmd_n,
  output logic [DW-1:0] cmd_word,
  output logic          cmd_bus,
  output logic          cmd_bcast,
  output logic          data_stb,
  output logic [DW-1:0] data_word,
  output logic          data_bus,
  output logic          abort_stb
);
  localparam int PW = $clog2(PULSE_CLKS + 1);
  localparam logic [PW-1:0] PLOAD = PW'(PULSE_CLKS - 1);

  logic [PW-1:0] pcnt;
  logic [DW-1:0] gword;
  logic          new_cmd;

  assign new_cmd = grant_a || grant_b;
  assign gword   = grant_a ? word_a : word_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_n     <= 1'b1;
      pcnt      <= '0;
      cmd_word  <= '0;
      cmd_bus   <= 1'b0;
      cmd_bcast <= 1'b0;
      data_stb  <= 1'b0;
      data_word <= '0;
      data_bus  <= 1'b0;
      abort_stb <= 1'b0;
    end else begin
      abort_stb <= abort_in;
      data_stb  <= pass_a || pass_b;
      if (pass_a || pass_b) begin
        data_word <= pass_a ? word_a : word_b;
        data_bus  <= !pass_a;
      end
      if (new_cmd) begin
        cmd_n     <= 1'b0;
        pcnt      <= PLOAD;
        cmd_word  <= gword;
        cmd_bus   <= !grant_a;
        cmd_bcast <= (gword[DW-1:ADDR_LSB] == BCAST_ADDR);
      end else if (!cmd_n) begin
        if (pcnt == '0) cmd_n <= 1'b1;
        else            pcnt  <= pcnt - 1'b1;
      end
    end
  end

  int unsigned low_run;
  always_ff @(posedge clk) begin
    if (rst)          low_run <= 0;
    else if (new_cmd) low_run <= 1;
    else if (!cmd_n)  low_run <= low_run + 1;
    else              low_run <= 0;
  end

  // R5
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    !cmd_n |-> (low_run <= PULSE_CLKS));
  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd_n && !new_cmd) |=> ($stable(cmd_word) && $stable(cmd_bus)));
  // R6
  abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    abort_stb |-> !cmd_n);
endmodule

// File: rtl/bus_word_validator.sv
module bus_word_validator
  import bwv_pkg::*;
#(
  parameter int CLKS_PER_BIT = 250,
  parameter int WORD_BITS    = 20,
  parameter int GAP_BITS     = 4,
  parameter int PULSE_CLKS   = 125
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    rt_addr,
  input  logic          a_rdy,
  input  logic          a_sync_cmd,
  input  logic [15:0]   a_data,
  input  logic          a_parity,
  input  logic          a_man_err,
  input  logic          b_rdy,
  input  logic          b_sync_cmd,
  input  logic [15:0]   b_data,
  input  logic          b_parity,
  input  logic          b_man_err,
  output logic          cmd_n,
  output logic [15:0]   cmd_word,
  output logic          cmd_bus,
  output logic          cmd_bcast,
  output logic          data_stb,
  output logic [15:0]   data_word,
  output logic          data_bus,
  output logic          abort_stb
);
  localparam int NBUS        = 2;
  localparam int WINDOW_BITS = WORD_BITS + GAP_BITS;

  logic          tick;
  logic [AW-1:0] rt_q;
  bus_word_t     bw       [NBUS];
  logic          cmd_cand [NBUS];
  logic          data_cand[NBUS];
  logic          open_win [NBUS];
  logic          grant    [NBUS];
  logic          pass     [NBUS];
  logic          take     [NBUS];
  logic          abort_c;

  // R7: terminal address captured only during reset
  always_ff @(posedge clk) begin
    if (rst) rt_q <= rt_addr;
  end

  assign bw[0] = '{rdy: a_rdy, sync_cmd: a_sync_cmd, data: a_data,
                   parity: a_parity, man_err: a_man_err};
  assign bw[1] = '{rdy: b_rdy, sync_cmd: b_sync_cmd, data: b_data,
                   parity: b_parity, man_err: b_man_err};

  bwv_bit_tick #(.CLKS_PER_BIT(CLKS_PER_BIT)) i_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  // R9: bus A wins a same-cycle command collision
  assign grant[0] = cmd_cand[0];
  assign grant[1] = cmd_cand[1] && !cmd_cand[0];
  // R6: a command on one bus drops the other bus's data
  assign pass[0]  = data_cand[0] && !grant[1];
  assign pass[1]  = data_cand[1] && !grant[0];
  assign abort_c  = (grant[0] && open_win[1]) || (grant[1] && open_win[0]);

  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    assign take[g] = grant[g] || pass[g];
    bwv_word_check #(.WINDOW_BITS(WINDOW_BITS)) i_chk (
      .clk      (clk),
      .rst      (rst),
      .bit_tick (tick),
      .w        (bw[g]),
      .rt_addr  (rt_q),
      .take     (take[g]),
      .cancel   (grant[NBUS-1-g]),
      .cmd_cand (cmd_cand[g]),
      .data_cand(data_cand[g]),
      .open_win (open_win[g])
    );
  end

  bwv_msg_out #(.PULSE_CLKS(PULSE_CLKS)) i_out (
    .clk      (clk),
    .rst      (rst),
    .grant_a  (grant[0]),
    .grant_b  (grant[1]),
    .pass_a   (pass[0]),
    .pass_b   (pass[1]),
    .abort_in (abort_c),
    .word_a   (a_data),
    .word_b   (b_data),
    .cmd_n    (cmd_n),
    .cmd_word (cmd_word),
    .cmd_bus  (cmd_bus),
    .cmd_bcast(cmd_bcast),
    .data_stb (data_stb),
    .data_word(data_word),
    .data_bus (data_bus),
    .abort_stb(abort_stb)
  );

  // R2
  cmd_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_n) |-> (cmd_word[15:11] == rt_q || cmd_word[15:11] == BCAST_ADDR));
  // R6
  no_data_on_abort_chk: assert property (@(posedge clk) disable iff (rst)
    !(data_stb && abort_stb));
  // R3
  single_window_chk: assert property (@(posedge clk) disable iff (rst)
    !(open_win[0] && open_win[1]));
endmodule

// File: tb/test_bus_word_validator.sv
module test_bus_word_validator;
  localparam int CPB = 2;
  localparam int WB  = 20;
  localparam int GB  = 2;
  localparam int PC  = 6;
  localparam int LIM = (WB + GB - 1) * CPB;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic [4:0] rt_addr;
  logic a_rdy, a_sync_cmd, a_parity, a_man_err;
  logic b_rdy, b_sync_cmd, b_parity, b_man_err;
  logic [15:0] a_data, b_data;
  logic cmd_n, cmd_bus, cmd_bcast, data_stb, data_bus, abort_stb;
  logic [15:0] cmd_word, data_word;

  bus_word_validator #(.CLKS_PER_BIT(CPB), .WORD_BITS(WB), .GAP_BITS(GB), .PULSE_CLKS(PC))
  i_bus_word_validator (
    .clk(clk), .rst(rst), .rt_addr(rt_addr),
    .a_rdy(a_rdy), .a_sync_cmd(a_sync_cmd), .a_data(a_data), .a_parity(a_parity), .a_man_err(a_man_err),
    .b_rdy(b_rdy), .b_sync_cmd(b_sync_cmd), .b_data(b_data), .b_parity(b_parity), .b_man_err(b_man_err),
    .cmd_n(cmd_n), .cmd_word(cmd_word), .cmd_bus(cmd_bus), .cmd_bcast(cmd_bcast),
    .data_stb(data_stb), .data_word(data_word), .data_bus(data_bus), .abort_stb(abort_stb)
  );

  int checks = 0;
  int errors = 0;
  string req = "R7";
  bit done = 0;

  // reference model state
  int rem = 0;
  logic [15:0] e_cword = '0, e_dword = '0;
  logic e_cbus = 0, e_bcast = 0, e_dstb = 0, e_dbus = 0, e_abort = 0;
  int age[2] = '{0, 0};
  bit alive[2] = '{0, 0};
  logic [4:0] m_rt = 5'd9;

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit good(logic [15:0] d, logic p, logic m);
    return !m && (^{d, p});
  endfunction

  task automatic step(input logic ra, sa, input logic [15:0] da, input logic pa_ok, ma,
                      input logic rb, sb, input logic [15:0] db, input logic pb_ok, mb);
    bit fol[2], cc[2], dc[2], g[2], ps[2], rdy[2];
    logic [15:0] d[2];
    @(negedge clk);
    chk("cmd_n", 16'(cmd_n), 16'(rem == 0));
    chk("cmd_word", cmd_word, e_cword);
    chk("cmd_bus", 16'(cmd_bus), 16'(e_cbus));
    chk("cmd_bcast", 16'(cmd_bcast), 16'(e_bcast));
    chk("data_stb", 16'(data_stb), 16'(e_dstb));
    chk("abort_stb", 16'(abort_stb), 16'(e_abort));
    if (e_dstb) begin
      chk("data_word", data_word, e_dword);
      chk("data_bus", 16'(data_bus), 16'(e_dbus));
    end
    a_rdy = ra; a_sync_cmd = sa; a_data = da; a_parity = pa_ok ? ~^da : ^da; a_man_err = ma;
    b_rdy = rb; b_sync_cmd = sb; b_data = db; b_parity = pb_ok ? ~^db : ^db; b_man_err = mb;
    rdy[0] = ra; rdy[1] = rb; d[0] = da; d[1] = db;
    for (int i = 0; i < 2; i++) fol[i] = alive[i] && (age[i] < LIM);
    cc[0] = ra && sa && good(da, a_parity, ma) && !fol[0] && (da[15:11] == m_rt || da[15:11] == 5'h1F);
    cc[1] = rb && sb && good(db, b_parity, mb) && !fol[1] && (db[15:11] == m_rt || db[15:11] == 5'h1F);
    dc[0] = ra && !sa && good(da, a_parity, ma) && fol[0];
    dc[1] = rb && !sb && good(db, b_parity, mb) && fol[1];
    g[0] = cc[0]; g[1] = cc[1] && !cc[0];
    ps[0] = dc[0] && !g[1]; ps[1] = dc[1] && !g[0];
    e_abort = (g[0] && fol[1]) || (g[1] && fol[0]);
    e_dstb = ps[0] || ps[1];
    if (e_dstb) begin e_dword = ps[0] ? da : db; e_dbus = !ps[0]; end
    if (g[0] || g[1]) begin
      rem = PC; e_cword = g[0] ? da : db; e_cbus = !g[0]; e_bcast = (e_cword[15:11] == 5'h1F);
    end else if (rem > 0) rem--;
    for (int i = 0; i < 2; i++) begin
      if (g[i] || ps[i]) begin alive[i] = 1; age[i] = 0; end
      else if (rdy[i] || g[1-i]) alive[i] = 0;
      else age[i]++;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, 1, 0, 0, 0, '0, 1, 0);
  endtask
  task automatic wa(logic s, logic [15:0] d, logic pok = 1, logic m = 0);
    step(1, s, d, pok, m, 0, 0, '0, 1, 0);
  endtask
  task automatic wb(logic s, logic [15:0] d, logic pok = 1, logic m = 0);
    step(0, 0, '0, 1, 0, 1, s, d, pok, m);
  endtask

  localparam logic [15:0] CMD9 = {5'd9, 11'h423};
  localparam logic [15:0] CMD9B = {5'd9, 11'h0C5};

  initial begin
    rst = 1; rt_addr = 5'd9;
    {a_rdy, a_sync_cmd, a_parity, a_man_err, b_rdy, b_sync_cmd, b_parity, b_man_err} = '0;
    a_data = '0; b_data = '0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0; rt_addr = 5'd3;
    // R7: reset state, no data before a command, latched address
    req = "R7"; idle(3);
    wa(0, 16'h1111); idle(60);
    wa(1, {5'd3, 11'h041}); idle(60);
    // R4 R5: command then contiguous data
    req = "R4"; wa(1, CMD9); idle(10);
    wa(0, 16'h1234); idle(10); wa(0, 16'hBEEF); idle(10); wa(0, 16'hA5A5); idle(60);
    wa(0, 16'h5555); idle(60);
    // R1: bad parity and bi-phase error commands rejected; R8 window stays shut
    req = "R1"; wa(1, CMD9, 0); idle(10); wa(0, 16'h0F0F); idle(60);
    wa(1, CMD9, 1, 1); idle(10); wa(0, 16'h0F0F); idle(60);
    req = "R8"; wa(1, CMD9); idle(10); wa(0, 16'h7777, 0); idle(10); wa(0, 16'h8888); idle(60);
    // R2: broadcast accepted, foreign address rejected
    req = "R2"; wa(1, {5'h1F, 11'h012}); idle(10); wa(0, 16'h4242); idle(60);
    wa(1, {5'd5, 11'h012}); idle(60);
    // R3: contiguous command rejected, chain closed
    req = "R3"; wa(1, CMD9); idle(10); wa(0, 16'h0101); idle(10);
    wa(1, CMD9B); idle(10); wa(0, 16'h0202); idle(60);
    // R6: command on B terminates A
    req = "R6"; wa(1, CMD9); idle(10); wa(0, 16'h3333); idle(10);
    wb(1, CMD9B); idle(10); wa(0, 16'h4444); idle(5); wb(0, 16'h6666); idle(60);
    wa(1, CMD9); idle(10);
    step(1, 0, 16'h9999, 1, 0, 1, 1, CMD9B, 1, 0); idle(10); wb(0, 16'hABCD); idle(60);
    // R9: simultaneous commands, A wins
    req = "R9"; step(1, 1, CMD9, 1, 0, 1, 1, CMD9B, 1, 0); idle(10);
    wb(0, 16'h1357); idle(5); wa(0, 16'h2468); idle(60);
    // R5: pulse restarted by a later command
    req = "R5"; wa(1, CMD9); idle(2); wb(1, CMD9B); idle(20);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule